// File: doc/BRIEF.md
# Response Flit Packer

This block sits between a target's bus response port and a 33-bit network-on-chip response channel. It takes response beats from the target and turns each response into a network packet. Each beat carries a 32-bit read data word, a last-beat flag, a 14-bit source identifier, a 2-bit error code, a 4-bit packet identifier and a 4-bit transaction identifier.

Short acknowledgements take a compact path. A write completion, or a compare-and-swap that succeeded, is a single beat whose data word is zero. Such a response goes out as one flit that carries only the routing and tag fields.

Every other response goes out as a header flit followed by one flit per data word. This covers burst reads of up to sixteen words, linked-load replies made of a signature word and a data word, and compare-and-swap failures whose data is 1. The format is chosen only after the first beat has been seen, so the first beat is always captured in a holding register before any flit leaves. Both sides use a valid/ready handshake.

Top module: `rsp_flit_packer`

## Requirements
- R1: A response of one beat (last flag set on the first beat) with a zero data word is sent as exactly one flit. In that flit, bit 32 = 1, bits 31:18 = source ID, bits 17:16 = error, bits 15:12 = packet ID, bits 11:8 = transaction ID, bits 7:1 = 0 and bit 0 = 0.
- R2: Every other response starts with a header flit. The header has bit 32 = 0, the same field positions as in R1 (taken from the first beat), bits 7:1 = 0 and bit 0 = 1.
- R3: After the header, each input beat gives one data flit, in arrival order. Bits 31:0 of a data flit hold the beat's data word, and bit 32 is 1 only on the flit of the beat that has its last flag set.
- R4: A single-beat response whose data word is not zero, for example a compare-and-swap failure that returns 1, uses the header-plus-data format: two flits, and the second has bit 32 = 1.
- R5: A response of two or more beats uses the header-plus-data format even when all of its data words are zero, for example a linked-load reply with a zero signature.
- R6: While out_valid is high and out_ready is low, out_valid stays high and out_flit does not change on the next cycle.
- R7: While the header flit, the compact flit or the first data flit is waiting to be sent, in_ready is low.
- R8: The cycle after the first beat of a response is accepted, out_valid is high.
- R9: In the first cycle after reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Response beat valid |
| in_ready | output | 1 | Response beat accepted |
| in_last | input | 1 | Last beat of the response |
| in_data | input | 32 | Read data word |
| in_srcid | input | 14 | Source identifier, used for routing the response |
| in_err | input | 2 | Error code |
| in_pktid | input | 4 | Packet identifier |
| in_trdid | input | 4 | Transaction identifier |
| out_valid | output | 1 | Network flit valid |
| out_ready | input | 1 | Network flit accepted |
| out_flit | output | 33 | Network response flit |

## Verification
The bench uses the package defaults: 32-bit data words, a 14-bit source ID and 4-bit packet and transaction tags. These leave seven padding bits in the header, so every field position in R1 and R2 is exercised.

A 20-cycle stall on the network side at the start holds a zero-data linked-load header back. This exposes the R6 and R7 behaviour.

Directed packets then cover:
- a compact acknowledgement;
- a compare-and-swap failure that returns 1;
- a sixteen-word burst.

Random packets follow, with random lengths, zero or random first words, and random valid and ready gaps. These reach the pass-through path under back-pressure on both sides.

// File: rtl/rspk_pkg.sv
package rspk_pkg;

    localparam int DATA_W  = 32;
    localparam int SRCID_W = 14;
    localparam int ERR_W   = 2;
    localparam int PKTID_W = 4;
    localparam int TRDID_W = 4;
    localparam int FLIT_W  = DATA_W + 1;
    localparam int HDR_W   = SRCID_W + ERR_W + PKTID_W + TRDID_W;
    localparam int PAD_W   = FLIT_W - 2 - HDR_W;

    typedef struct packed {
        logic [SRCID_W-1:0] srcid;
        logic [ERR_W-1:0]   err;
        logic [PKTID_W-1:0] pktid;
        logic [TRDID_W-1:0] trdid;
    } rsp_hdr_t;

    typedef struct packed {
        rsp_hdr_t          hdr;
        logic [DATA_W-1:0] data;
        logic              last;
    } rsp_beat_t;

    typedef enum logic [1:0] {
        ST_FILL = 2'd0,
        ST_HEAD = 2'd1,
        ST_WORD = 2'd2,
        ST_PASS = 2'd3
    } seq_state_e;

    // Compact flit when the response is one beat carrying a zero word.
    function automatic logic is_compact(rsp_beat_t b);
        return b.last && (b.data == '0);
    endfunction

    // Head flit: the top bit ends the packet only for the compact form,
    // and the bottom bit tells the receiver that data flits follow.
    function automatic logic [FLIT_W-1:0] make_head(rsp_hdr_t h, logic compact);
        return {compact, h, {PAD_W{1'b0}}, ~compact};
    endfunction

    function automatic logic [FLIT_W-1:0] make_word(logic [DATA_W-1:0] d, logic last);
        return {last, d};
    endfunction

endpackage

// File: rtl/rspk_hold.sv
module rspk_hold
    import rspk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  rsp_beat_t beat_in,
    output rsp_beat_t beat_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
        end else if (load) begin
            beat_q <= beat_in;
        end
    end

endmodule

// File: rtl/rspk_seq.sv
module rspk_seq
    import rspk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic       in_last,
    input  logic       out_ready,
    input  logic       compact,
    input  logic       held_last,
    output seq_state_e state_q,
    output logic       in_ready,
    output logic       out_valid,
    output logic       load
);

    seq_state_e state_d;

    always_comb begin
        state_d   = state_q;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        load      = 1'b0;
        unique case (state_q)
            ST_FILL: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    load    = 1'b1;
                    state_d = ST_HEAD;
                end
            end
            ST_HEAD: begin
                out_valid = 1'b1;
                if (out_ready) begin
                    state_d = compact ? ST_FILL : ST_WORD;
                end
            end
            ST_WORD: begin
                out_valid = 1'b1;
                if (out_ready) begin
                    state_d = held_last ? ST_FILL : ST_PASS;
                end
            end
            ST_PASS: begin
                out_valid = in_valid;
                in_ready  = out_ready;
                if (in_valid && out_ready && in_last) begin
                    state_d = ST_FILL;
                end
            end
            default: state_d = ST_FILL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FILL;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/rspk_fmt.sv
module rspk_fmt
    import rspk_pkg::*;
(
    input  seq_state_e        state,
    input  rsp_beat_t         held,
    input  logic              compact,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic [FLIT_W-1:0] flit
);

    always_comb begin
        unique case (state)
            ST_HEAD: flit = make_head(held.hdr, compact);
            ST_WORD: flit = make_word(held.data, held.last);
            ST_PASS: flit = make_word(in_data, in_last);
            default: flit = '0;
        endcase
    end

endmodule

// File: rtl/rsp_flit_packer.sv
module rsp_flit_packer
    import rspk_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic               in_last,
    input  logic [DATA_W-1:0]  in_data,
    input  logic [SRCID_W-1:0] in_srcid,
    input  logic [ERR_W-1:0]   in_err,
    input  logic [PKTID_W-1:0] in_pktid,
    input  logic [TRDID_W-1:0] in_trdid,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [FLIT_W-1:0]  out_flit
);

    rsp_beat_t  beat_in;
    rsp_beat_t  held_q;
    logic       load;
    logic       compact;
    seq_state_e seq_state;

    always_comb begin
        beat_in.hdr.srcid = in_srcid;
        beat_in.hdr.err   = in_err;
        beat_in.hdr.pktid = in_pktid;
        beat_in.hdr.trdid = in_trdid;
        beat_in.data      = in_data;
        beat_in.last      = in_last;
    end

    assign compact = is_compact(held_q);

    rspk_hold u_hold (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .beat_in (beat_in),
        .beat_q  (held_q)
    );

    rspk_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .out_ready (out_ready),
        .compact   (compact),
        .held_last (held_q.last),
        .state_q   (seq_state),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .load      (load)
    );

    rspk_fmt u_fmt (
        .state   (seq_state),
        .held    (held_q),
        .compact (compact),
        .in_data (in_data),
        .in_last (in_last),
        .flit    (out_flit)
    );

endmodule

// File: rtl/rspk_checker.sv
module rspk_checker
    import rspk_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [FLIT_W-1:0] out_flit,
    input logic [DATA_W-1:0] in_data,
    input seq_state_e        state
);

    assert_stall_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_flit)));

    assert_first_beat_out_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !out_valid) |=> out_valid);

    assert_no_take_pending_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && in_ready) |-> (state == ST_PASS));

    assert_head_pad_R1: assert property (@(posedge clk) disable iff (rst)
        (out_valid && state == ST_HEAD) |-> (out_flit[PAD_W:1] == '0));

    assert_pass_data_R3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && state == ST_PASS) |-> (out_flit[DATA_W-1:0] == in_data));

    assert_reset_idle_R9: assert property (@(posedge clk)
        rst |=> (!out_valid && in_ready));

endmodule

bind rsp_flit_packer rspk_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_flit  (out_flit),
    .in_data   (in_data),
    .state     (seq_state)
);

// File: tb/rsp_flit_packer_tb.sv
`timescale 1ns/1ps
module rsp_flit_packer_tb;
    import rspk_pkg::*;

    localparam int STALL_CYC = 20;
    localparam int WD_CYC    = 100000;

    logic               clk = 1'b0;
    logic               rst;
    logic               in_valid;
    logic               in_ready;
    logic               in_last;
    logic [DATA_W-1:0]  in_data;
    logic [SRCID_W-1:0] in_srcid;
    logic [ERR_W-1:0]   in_err;
    logic [PKTID_W-1:0] in_pktid;
    logic [TRDID_W-1:0] in_trdid;
    logic               out_valid;
    logic               out_ready;
    logic [FLIT_W-1:0]  out_flit;

    always #2.5 clk = ~clk;

    rsp_flit_packer u_dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_last(in_last),
        .in_data(in_data), .in_srcid(in_srcid), .in_err(in_err),
        .in_pktid(in_pktid), .in_trdid(in_trdid),
        .out_valid(out_valid), .out_ready(out_ready), .out_flit(out_flit)
    );

    rsp_beat_t        beat_q[$];
    logic [FLIT_W-1:0] exp_q[$];
    string            tag_q[$];
    int               n_tests = 0;
    int               n_fail  = 0;

    task automatic check(input bit ok, input string req, input logic [FLIT_W-1:0] act,
                         input logic [FLIT_W-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [FLIT_W-1:0] exp_head(rsp_hdr_t h, bit compact);
        logic [FLIT_W-1:0] f;
        f = '0;
        f[32]    = compact;
        f[31:18] = h.srcid;
        f[17:16] = h.err;
        f[15:12] = h.pktid;
        f[11:8]  = h.trdid;
        f[0]     = !compact;
        return f;
    endfunction

    task automatic add_pkt(input int n, input logic [31:0] first, input bit zero_all,
                           input string tag);
        rsp_hdr_t  h;
        rsp_beat_t b;
        bit        compact;
        h.srcid = SRCID_W'($urandom);
        h.err   = ERR_W'($urandom);
        h.pktid = PKTID_W'($urandom);
        h.trdid = TRDID_W'($urandom);
        compact = (n == 1) && (first == 0);
        exp_q.push_back(exp_head(h, compact));
        tag_q.push_back(compact ? "R1" : "R2");
        for (int i = 0; i < n; i++) begin
            b.hdr  = h;
            b.data = (i == 0) ? first : (zero_all ? 32'd0 : $urandom);
            b.last = (i == n - 1);
            beat_q.push_back(b);
            if (!compact) begin
                exp_q.push_back({b.last, b.data});
                tag_q.push_back(tag);
            end
        end
    endtask

    initial begin
        int unsigned seed_v;
        int          cyc;
        bit          hold_in;
        bit          prev_stall;
        bit          prev_first;
        bit          in_fire;
        bit          out_fire;
        logic [FLIT_W-1:0] prev_flit;

        seed_v = $urandom(32'd20517);
        rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0; in_last = 1'b0;
        in_data = '0; in_srcid = '0; in_err = '0; in_pktid = '0; in_trdid = '0;

        add_pkt(2, 32'd0, 1'b1, "R5");          // zero linked-load, stalled
        add_pkt(1, 32'd0, 1'b0, "R1");          // compact acknowledgement
        add_pkt(1, 32'd1, 1'b0, "R4");          // compare-and-swap failure
        add_pkt(16, $urandom | 32'd1, 1'b0, "R3");
        for (int p = 0; p < 150; p++) begin
            int n;
            n = ($urandom % 3 == 0) ? 1 : 1 + int'($urandom % 16);
            add_pkt(n, ($urandom % 2 == 0) ? 32'd0 : $urandom, 1'b0, "R3");
        end

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(!out_valid && in_ready, "R9", {31'd0, out_valid, in_ready}, 33'd1);

        cyc = 0; hold_in = 0; prev_stall = 0; prev_first = 0; prev_flit = '0;
        while (exp_q.size() > 0 && cyc < WD_CYC) begin
            @(posedge clk); #1;
            if (!hold_in) begin
                in_valid = (beat_q.size() > 0) && ($urandom % 4 != 0);
                if (in_valid) begin
                    in_srcid = beat_q[0].hdr.srcid; in_err = beat_q[0].hdr.err;
                    in_pktid = beat_q[0].hdr.pktid; in_trdid = beat_q[0].hdr.trdid;
                    in_data  = beat_q[0].data;      in_last  = beat_q[0].last;
                end
            end
            out_ready = (cyc < STALL_CYC) ? 1'b0 : ($urandom % 4 != 0);

            @(negedge clk);
            if (prev_stall)
                check(out_valid && out_flit == prev_flit, "R6", out_flit, prev_flit);
            if (prev_first)
                check(out_valid, "R8", {32'd0, out_valid}, 33'd1);
            if (cyc < STALL_CYC && out_valid)
                check(!in_ready, "R7", {32'd0, in_ready}, 33'd0);

            in_fire  = in_valid && in_ready;
            out_fire = out_valid && out_ready;
            prev_first = in_fire && !out_valid;
            if (in_fire) void'(beat_q.pop_front());
            hold_in = in_valid && !in_fire;
            if (out_fire) begin
                check(out_flit == exp_q[0], tag_q[0], out_flit, exp_q[0]);
                void'(exp_q.pop_front());
                void'(tag_q.pop_front());
            end
            prev_stall = out_valid && !out_ready;
            prev_flit  = out_flit;
            cyc++;
        end

        if (cyc >= WD_CYC) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d flits left expected 0", exp_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule